// File: doc/BRIEF.md
# Reloading Tick Timer with Free-Running Timestamp Counter

The block holds two independent counters behind a small word-addressed register bus. The first is a 16-bit down-counter that advances on one of two externally generated tick strobes. When it passes zero, it either reloads from a software-written period register or wraps to all ones. Each pass through zero latches a level interrupt. That interrupt stays asserted until software writes the clear address. The second is a 40-bit up-counter that advances on the fast tick strobe only. Software starts and stops it through a single enable bit and reads it as a timestamp. It never reloads and has no interrupt.

A typical driver programs the period while the down-counter is stopped. Control value 0x48 keeps the counter stopped with periodic mode and the fast tick selected. Control value 0xC8 then starts it. The period in ticks is the programmed value plus one. The driver also sets the enable bit of the timestamp counter and measures the time between interrupts by subtracting successive reads of its low word. Tick generation is outside the block: both strobes arrive as single-cycle enables in the bus clock domain.

Register map (word address on `bus_addr`): 0 period, 1 current count (read only), 2 control, 3 interrupt clear (write only, reads 0), 4 timestamp bits 31:0 (read only), 5 timestamp bits 39:32 in data bits 7:0, with the timestamp enable in data bit 8.

Top module: `tick_timer`

## Requirements
- R1: After reset, the count, period, control, timestamp counter, timestamp enable and `irq` are all zero.
- R2: While control bit 7 (run) is set, each selected tick lowers the count by one. While run is clear, ticks leave the count unchanged.
- R3: With control bit 6 set (periodic), a selected tick at count zero reloads the period value, so the zero crossing repeats every period+1 ticks.
- R4: With control bit 6 clear, a selected tick at count zero sets the count to 0xFFFF.
- R5: A selected tick at count zero while running sets `irq`. `irq` then stays high until any write to address 3, which drops it one cycle later.
- R6: If a zero-crossing tick and a write to address 3 fall in the same cycle, `irq` stays high.
- R7: Control bit 3 set selects `tick_fast` as the down-counter's tick. Bit 3 clear selects `tick_slow`. The strobe that is not selected has no effect.
- R8: A period write while run is clear also loads the count at once. A period write while running leaves the count alone until the next selected tick. That tick loads the new period with no decrement and no interrupt.
- R9: While the timestamp enable (address 5, bit 8) is set, each `tick_fast` raises the 40-bit timestamp counter by one. `tick_slow` never changes it.
- R10: Writing address 5 sets the timestamp enable from data bit 8. Writing a 0 there also clears the counter. Reads of address 5 return bits 39:32 in data bits 7:0 and the enable in bit 8.
- R11: A read returns its data on `bus_rdata` one clock after the address is presented. Control reads back only bits 7, 6 and 3. The period reads back at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_slow | input | 1 | Slow tick enable strobe |
| tick_fast | input | 1 | Fast tick enable strobe |
| irq | output | 1 | Level interrupt from the down-counter's zero crossing |

## Verification
A zero crossing and a software clear can land in the same clock, and the block must keep the interrupt pending then rather than lose the new event. The bench sets a period of zero so that every selected tick crosses zero. It then raises the fast tick and the clear write on the same falling edge. One cycle later `irq` must still read high. A plain clear afterwards must drop it. A second overlap sits between a period write and the tick that consumes a pending reload. That case is judged by the count seen on the next read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // word addresses of the register bus
  localparam int ADR_PERIOD  = 0;
  localparam int ADR_COUNT   = 1;
  localparam int ADR_CTRL    = 2;
  localparam int ADR_CLEAR   = 3;
  localparam int ADR_STAMP_L = 4;
  localparam int ADR_STAMP_H = 5;

  // control register bit positions
  localparam int CTRL_RUN_BIT  = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;

  // timestamp high register enable bit
  localparam int STAMP_EN_BIT = 8;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fast;
  } ctrl_t;

endpackage

// File: rtl/tick_timer_down.sv
module tick_timer_down #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             periodic,
  input  logic             tick,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_in,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] count_q,
  output logic             reload_pend,
  output logic             zero_cross
);

  localparam logic [CNT_W-1:0] WRAP_VAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] next_after_zero;

  assign next_after_zero = periodic ? period_q : WRAP_VAL;
  assign zero_cross      = run && tick && !reload_pend && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '0;
      period_q    <= '0;
      reload_pend <= 1'b0;
    end else begin
      if (!run) begin
        reload_pend <= 1'b0;
      end else if (tick) begin
        if (reload_pend) begin
          count_q     <= period_q;
          reload_pend <= 1'b0;
        end else if (count_q == '0) begin
          count_q <= next_after_zero;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      if (period_we) begin
        period_q <= period_in;
        if (run) begin
          reload_pend <= 1'b1;
        end else begin
          count_q <= period_in;
        end
      end
    end
  end

endmodule

// File: rtl/tick_timer_stamp.sv
module tick_timer_stamp #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en_we,
  input  logic             en_in,
  output logic             en_q,
  output logic [CNT_W-1:0] count_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      count_q <= '0;
    end else if (en_we) begin
      en_q <= en_in;
      if (!en_in) begin
        count_q <= '0;
      end
    end else if (en_q && tick) begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int DOWN_W  = 16,
  parameter int STAMP_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic              irq
);

  localparam int STAMP_HI_W = STAMP_W - DATA_W;

  ctrl_t              ctrl_q;
  logic               wr_period;
  logic               wr_ctrl;
  logic               wr_clear;
  logic               wr_stamp_hi;
  logic               rd_access;
  logic               sel_tick;
  logic [DOWN_W-1:0]  period_q;
  logic [DOWN_W-1:0]  down_count;
  logic               down_pend;
  logic               zero_cross;
  logic               stamp_en;
  logic [STAMP_W-1:0] stamp_count;
  logic [DATA_W-1:0]  rd_mux;

  assign wr_period   = bus_en && bus_we && (bus_addr == ADDR_W'(ADR_PERIOD));
  assign wr_ctrl     = bus_en && bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  assign wr_clear    = bus_en && bus_we && (bus_addr == ADDR_W'(ADR_CLEAR));
  assign wr_stamp_hi = bus_en && bus_we && (bus_addr == ADDR_W'(ADR_STAMP_H));
  assign rd_access   = bus_en && !bus_we;

  assign sel_tick = ctrl_q.fast ? tick_fast : tick_slow;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run      <= bus_wdata[CTRL_RUN_BIT];
      ctrl_q.periodic <= bus_wdata[CTRL_PER_BIT];
      ctrl_q.fast     <= bus_wdata[CTRL_FAST_BIT];
    end
  end

  tick_timer_down #(.CNT_W(DOWN_W)) u_down (
    .clk         (clk),
    .rst         (rst),
    .run         (ctrl_q.run),
    .periodic    (ctrl_q.periodic),
    .tick        (sel_tick),
    .period_we   (wr_period),
    .period_in   (bus_wdata[DOWN_W-1:0]),
    .period_q    (period_q),
    .count_q     (down_count),
    .reload_pend (down_pend),
    .zero_cross  (zero_cross)
  );

  tick_timer_stamp #(.CNT_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_fast),
    .en_we   (wr_stamp_hi),
    .en_in   (bus_wdata[STAMP_EN_BIT]),
    .en_q    (stamp_en),
    .count_q (stamp_count)
  );

  // a new zero crossing outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (zero_cross) begin
      irq <= 1'b1;
    end else if (wr_clear) begin
      irq <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(ADR_PERIOD):  rd_mux = DATA_W'(period_q);
      ADDR_W'(ADR_COUNT):   rd_mux = DATA_W'(down_count);
      ADDR_W'(ADR_CTRL): begin
        rd_mux[CTRL_RUN_BIT]  = ctrl_q.run;
        rd_mux[CTRL_PER_BIT]  = ctrl_q.periodic;
        rd_mux[CTRL_FAST_BIT] = ctrl_q.fast;
      end
      ADDR_W'(ADR_STAMP_L): rd_mux = stamp_count[DATA_W-1:0];
      ADDR_W'(ADR_STAMP_H): begin
        rd_mux[STAMP_HI_W-1:0] = stamp_count[STAMP_W-1:DATA_W];
        rd_mux[STAMP_EN_BIT]   = stamp_en;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_access) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DOWN_W  = 16,
  parameter int STAMP_W = 40
) (
  input logic               clk,
  input logic               rst,
  input logic               irq,
  input logic               wr_clear,
  input logic               wr_period,
  input logic               wr_stamp_hi,
  input logic               run,
  input logic               periodic,
  input logic               sel_tick,
  input logic               tick_fast,
  input logic [DOWN_W-1:0]  down_count,
  input logic               down_pend,
  input logic [STAMP_W-1:0] stamp_count,
  input logic               stamp_en
);

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq && !wr_clear |=> irq); // R5

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    wr_clear && !sel_tick |=> !irq); // R5

  AST_CROSS_RAISES: assert property (@(posedge clk) disable iff (rst)
    run && sel_tick && !down_pend && (down_count == '0) |=> irq); // R6

  AST_WRAP_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    run && !periodic && sel_tick && !down_pend && (down_count == '0)
    |=> (down_count == {DOWN_W{1'b1}})); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    run && sel_tick && !down_pend && (down_count != '0)
    |=> (down_count == DOWN_W'($past(down_count) - 1'b1))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel_tick && !wr_period |=> $stable(down_count)); // R2

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    stamp_en && tick_fast && !wr_stamp_hi
    |=> (stamp_count == STAMP_W'($past(stamp_count) + 1'b1))); // R9

  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_fast && !wr_stamp_hi |=> $stable(stamp_count)); // R9

  AST_STAMP_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !stamp_en |-> (stamp_count == '0)); // R10

endmodule

bind tick_timer tick_timer_chk #(.DOWN_W(DOWN_W), .STAMP_W(STAMP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq         (irq),
  .wr_clear    (wr_clear),
  .wr_period   (wr_period),
  .wr_stamp_hi (wr_stamp_hi),
  .run         (ctrl_q.run),
  .periodic    (ctrl_q.periodic),
  .sel_tick    (sel_tick),
  .tick_fast   (tick_fast),
  .down_count  (down_count),
  .down_pend   (down_pend),
  .stamp_count (stamp_count),
  .stamp_en    (stamp_en)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq)
  );

  // {period[15:0], fast ticks[7:0], expected count[15:0], expected irq}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {16'd5,   8'd3,   16'd2,   1'b0},
    {16'd5,   8'd5,   16'd0,   1'b0},
    {16'd5,   8'd6,   16'd5,   1'b1},
    {16'd5,   8'd8,   16'd3,   1'b1},
    {16'd0,   8'd0,   16'd0,   1'b0},
    {16'd0,   8'd1,   16'd0,   1'b1},
    {16'd3,   8'd9,   16'd2,   1'b1},
    {16'd200, 8'd201, 16'd200, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic pulse(input bit fast);
    @(negedge clk);
    if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(1, v); chk("R1 count", v, 0);
    rd(0, v); chk("R1 period", v, 0);
    rd(2, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 stamp lo", v, 0);
    rd(5, v); chk("R1 stamp hi", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 table of periods and tick counts on the fast strobe
    for (int i = 0; i < NV; i++) begin
      wr(2, 32'h48);
      wr(3, 0);
      wr(0, 32'(VEC[i][40:25]));
      wr(2, 32'hC8);
      for (int t = 0; t < int'(VEC[i][24:17]); t++) pulse(1'b1);
      rd(1, v);
      chk("R3 count after ticks", v, 32'(VEC[i][16:1]));
      chk("R3 irq after ticks", 32'(irq), 32'(VEC[i][0]));
    end

    // R9 timestamp stayed idle while disabled
    rd(4, v); chk("R9 stamp idle while off", v, 0);

    // R6 zero crossing and clear in the same cycle
    wr(2, 32'h48); wr(3, 0); wr(0, 0); wr(2, 32'hC8);
    pulse(1'b1);
    chk("R5 irq raised", 32'(irq), 1);
    repeat (3) @(negedge clk);
    chk("R5 irq held", 32'(irq), 1);
    @(negedge clk);
    tick_fast = 1'b1; bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd3;
    @(negedge clk);
    tick_fast = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    chk("R6 irq kept on overlap", 32'(irq), 1);
    wr(3, 32'h0);
    chk("R5 irq cleared", 32'(irq), 0);

    // R2 ticks ignored while stopped
    wr(2, 32'h48); wr(0, 7);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    rd(1, v); chk("R2 stopped holds", v, 7);

    // R7 slow tick selection
    wr(0, 10); wr(2, 32'hC0);
    pulse(1'b1); pulse(1'b1);
    rd(1, v); chk("R7 fast ignored", v, 10);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    rd(1, v); chk("R7 slow counts", v, 7);

    // R4 wrap to all ones
    wr(2, 32'h08); wr(3, 0); wr(0, 1); wr(2, 32'h88);
    pulse(1'b1); pulse(1'b1);
    rd(1, v); chk("R4 wrap value", v, 32'hFFFF);
    chk("R4 irq on wrap", 32'(irq), 1);
    pulse(1'b1);
    rd(1, v); chk("R4 continues down", v, 32'hFFFE);

    // R8 period write while running
    wr(2, 32'h48); wr(3, 0); wr(0, 5); wr(2, 32'hC8);
    pulse(1'b1);
    rd(1, v); chk("R8 first step", v, 4);
    wr(0, 9);
    rd(1, v); chk("R8 count untouched by write", v, 4);
    pulse(1'b1);
    rd(1, v); chk("R8 loaded on tick", v, 9);
    chk("R8 no irq on load", 32'(irq), 0);
    pulse(1'b1);
    rd(1, v); chk("R8 counts from new period", v, 8);

    // R11 readbacks
    rd(0, v); chk("R11 period readback", v, 9);
    wr(2, 32'hFF);
    rd(2, v); chk("R11 ctrl bits only", v, 32'hC8);
    rd(3, v); chk("R11 clear reads zero", v, 0);

    // R9 / R10 timestamp counter
    wr(5, 32'h100);
    rd(5, v); chk("R10 enable readback", v, 32'h100);
    for (int t = 0; t < 5; t++) pulse(1'b1);
    pulse(1'b0); pulse(1'b0);
    rd(4, v); chk("R9 stamp counts fast", v, 5);
    wr(5, 32'h0);
    rd(4, v); chk("R10 disable clears lo", v, 0);
    rd(5, v); chk("R10 disable clears hi", v, 0);
    pulse(1'b1);
    rd(4, v); chk("R10 stays off", v, 0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule